// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Front End

This block sits between a host byte bus and the two channels of a serial controller. Each channel shows the host just two byte locations, told apart by one address line: a control location and a data location. Registers other than data are reached indirectly. A control write while the channel's pointer is zero loads the pointer, and the following control access (read or write) lands on the register it names, after which the pointer falls back to zero.

The same pointer-loading write also carries one-shot commands. Bits 5:3 select a latch or interrupt reset, and bits 7:6 select a CRC or underrun reset. Each command becomes a one-clock strobe toward the serial datapath. The block holds the write-register file, which it presents as flat configuration buses. It also holds the master control register, which both channels share and which can reset either channel or everything. A read multiplexer picks status, received data or stored bytes for the host.

Top module: `sio_regport`

## Requirements
- R1: After reset every pointer is zero, so a control read of a channel returns that channel's byte of `rr0_in`; all strobes and both configuration buses are zero.
- R2: A control write at pointer zero loads the pointer from bits 2:0, plus 8 when bits 5:3 equal 001; so values 0x00 to 0x0F name registers 0 to 15 directly.
- R3: A control read or write made while the pointer is nonzero reaches the pointed register and returns the pointer to zero; a control read at pointer zero leaves it at zero.
- R4: A control write to register N (N not 0, 8, 2 or 9) stores the byte in that channel's configuration bus at bits [8N+7:8N], visible from the clock edge that takes the write; with no write the buses hold.
- R5: A data-port write, or a control write to register 8, pulses `tx_load` of that channel (bit 0 channel A, bit 1 channel B) for one clock and stores nothing. A data-port read, or a control read of register 8, returns that channel's byte of `rxd_in` in the same cycle and pulses `rx_take` for one clock.
- R6: A control write at pointer zero pulses one `cmd` bit per code for one clock: bits 5:3 = 010,011,100,101,110,111 give cmd bits 0..5 (latch reset, abort, next-rx interrupt, tx interrupt reset, error reset, in-service reset); bits 7:6 = 01,10,11 give cmd bits 6,7,8 (rx CRC, tx CRC, underrun reset). A write at nonzero pointer pulses nothing.
- R7: Control reads return: register 1 the channel's `rr1_in` byte, 10 its `rr10_in` byte, 12, 13, 15 the stored bytes, 3 `ipend_in` on channel A and 0x00 on B; registers 4-7, 9, 11 and 14 read 0x00.
- R8: Register 2 is one shared byte writable from either channel and shown at byte 2 of both buses; channel A reads it back, channel B reads `vec_in` instead.
- R9: Register 9 is one shared byte. Bits 7:6 = 11 clear every stored byte and both pointers and pulse `chan_rst` = 11; 10 clears channel A's own bytes (not 2 or 9) with `chan_rst` = 01; 01 does the same for B with `chan_rst` = 10. Otherwise bits 5:0 are stored and bits 7:6 are stored as zero.
- R10: Accesses to one channel leave the other channel's pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_b | input | 1 | Channel select, 1 = channel B |
| bus_addr | input | 1 | 0 = control location, 1 = data location |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |
| rr0_in | input | 16 | Status byte per channel, B in 15:8 |
| rr1_in | input | 16 | Receive condition byte per channel |
| rr10_in | input | 16 | Auxiliary status byte per channel |
| rxd_in | input | 16 | Received character per channel |
| vec_in | input | 8 | Status-modified vector for channel B reads |
| ipend_in | input | 8 | Interrupt pending byte for channel A reads |
| cfg_a | output | 128 | Channel A write registers, byte N at 8N |
| cfg_b | output | 128 | Channel B write registers, byte N at 8N |
| cmd_a | output | 9 | Channel A command strobes |
| cmd_b | output | 9 | Channel B command strobes |
| tx_load | output | 2 | Transmit buffer load strobes |
| rx_take | output | 2 | Received character taken strobes |
| chan_rst | output | 2 | Channel reset strobes |

## Verification
Read data is combinational, so it is sampled a quarter period after the access is driven, in the same cycle, before the edge that takes the access. Every strobe and every configuration byte is registered once. They are therefore sampled at the falling edge right after the capturing edge, while a strobe is still high, and a second read at that point confirms that the pointer has fallen back. Command codes come from a table that also records the expected strobe word, and each entry checks both the addressed and the other channel.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;
    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int NCH  = 2;
    localparam int PW   = $clog2(NREG);
    localparam int NCMD = 9;

    localparam logic [PW-1:0] REG_CMD    = 4'd0;
    localparam logic [PW-1:0] REG_STAT   = 4'd1;
    localparam logic [PW-1:0] REG_VEC    = 4'd2;
    localparam logic [PW-1:0] REG_PEND   = 4'd3;
    localparam logic [PW-1:0] REG_DATA   = 4'd8;
    localparam logic [PW-1:0] REG_MASTER = 4'd9;
    localparam logic [PW-1:0] REG_AUX    = 4'd10;
    localparam logic [PW-1:0] REG_TCL    = 4'd12;
    localparam logic [PW-1:0] REG_TCH    = 4'd13;
    localparam logic [PW-1:0] REG_IEN    = 4'd15;

    localparam int CMD_RST_EXT   = 0;
    localparam int CMD_ABORT     = 1;
    localparam int CMD_RX_NEXT   = 2;
    localparam int CMD_RST_TXI   = 3;
    localparam int CMD_RST_ERR   = 4;
    localparam int CMD_RST_IUS   = 5;
    localparam int CMD_RST_RXCRC = 6;
    localparam int CMD_RST_TXCRC = 7;
    localparam int CMD_RST_EOM   = 8;

    typedef struct packed {
        logic [PW-1:0]   ptr;
        logic [NCMD-1:0] cmd;
        logic            txl;
        logic            rxt;
    } ptr_st_t;

    typedef struct packed {
        logic [NCH-1:0][NREG-1:0][DW-1:0] mem;
        logic [NCH-1:0]                   rst;
    } wf_st_t;
endpackage

// File: rtl/sio_chan_ptr.sv
module sio_chan_ptr
    import sio_regport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_rd,
    input  logic            dat_wr,
    input  logic            dat_rd,
    input  logic            clr_ptr,
    input  logic [DW-1:0]   wdata,
    output logic [PW-1:0]   ptr,
    output logic            reg_we,
    output logic [NCMD-1:0] cmd,
    output logic            tx_load,
    output logic            rx_take
);
    ptr_st_t    st_d, st_q;
    logic [2:0] grp;
    logic [1:0] crc;

    assign grp = wdata[5:3];
    assign crc = wdata[7:6];

    always_comb begin
        st_d     = st_q;
        st_d.cmd = '0;
        st_d.txl = dat_wr;
        st_d.rxt = dat_rd;
        if (ctl_wr && st_q.ptr == REG_CMD) begin
            st_d.ptr = {grp == 3'b001, wdata[2:0]};
            case (grp)
                3'd2:    st_d.cmd[CMD_RST_EXT] = 1'b1;
                3'd3:    st_d.cmd[CMD_ABORT]   = 1'b1;
                3'd4:    st_d.cmd[CMD_RX_NEXT] = 1'b1;
                3'd5:    st_d.cmd[CMD_RST_TXI] = 1'b1;
                3'd6:    st_d.cmd[CMD_RST_ERR] = 1'b1;
                3'd7:    st_d.cmd[CMD_RST_IUS] = 1'b1;
                default: ;
            endcase
            case (crc)
                2'd1:    st_d.cmd[CMD_RST_RXCRC] = 1'b1;
                2'd2:    st_d.cmd[CMD_RST_TXCRC] = 1'b1;
                2'd3:    st_d.cmd[CMD_RST_EOM]   = 1'b1;
                default: ;
            endcase
        end else if (ctl_wr || ctl_rd) begin
            st_d.ptr = REG_CMD;
            if (st_q.ptr == REG_DATA) begin
                if (ctl_wr) st_d.txl = 1'b1;
                else        st_d.rxt = 1'b1;
            end
        end
        if (clr_ptr) st_d.ptr = REG_CMD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr     = st_q.ptr;
    assign reg_we  = ctl_wr && (st_q.ptr != REG_CMD);
    assign cmd     = st_q.cmd;
    assign tx_load = st_q.txl;
    assign rx_take = st_q.rxt;
endmodule

// File: rtl/sio_wreg_file.sv
module sio_wreg_file
    import sio_regport_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       we,
    input  logic [PW-1:0]        idx_a,
    input  logic [PW-1:0]        idx_b,
    input  logic [DW-1:0]        wdata,
    output logic [NREG*DW-1:0]   cfg_a,
    output logic [NREG*DW-1:0]   cfg_b,
    output logic [NCH-1:0]       clr_ptr,
    output logic [NCH-1:0]       chan_rst
);
    wf_st_t                   wf_d, wf_q;
    logic [NCH-1:0]           kill;
    logic                     full;
    logic [NCH-1:0][PW-1:0]   idx;
    logic [NREG-1:0][DW-1:0]  view_b;

    assign idx[0] = idx_a;
    assign idx[1] = idx_b;

    always_comb begin
        wf_d     = wf_q;
        wf_d.rst = '0;
        kill     = '0;
        for (int c = 0; c < NCH; c++) begin
            if (we[c]) begin
                if (idx[c] == REG_MASTER) begin
                    wf_d.mem[0][REG_MASTER] = {2'b00, wdata[DW-3:0]};
                    kill[0] = wdata[DW-1];
                    kill[1] = wdata[DW-2];
                end else if (idx[c] == REG_VEC) begin
                    wf_d.mem[0][REG_VEC] = wdata;
                end else if (idx[c] != REG_CMD && idx[c] != REG_DATA) begin
                    wf_d.mem[c][idx[c]] = wdata;
                end
            end
        end
        full = &kill;
        for (int c = 0; c < NCH; c++) begin
            if (kill[c]) begin
                for (int i = 0; i < NREG; i++) begin
                    if (full || (PW'(i) != REG_VEC && PW'(i) != REG_MASTER))
                        wf_d.mem[c][i] = '0;
                end
            end
        end
        wf_d.rst = kill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wf_q <= '0;
        else        wf_q <= wf_d;
    end

    always_comb begin
        view_b             = wf_q.mem[1];
        view_b[REG_VEC]    = wf_q.mem[0][REG_VEC];
        view_b[REG_MASTER] = wf_q.mem[0][REG_MASTER];
    end

    assign cfg_a    = wf_q.mem[0];
    assign cfg_b    = view_b;
    assign clr_ptr  = kill;
    assign chan_rst = wf_q.rst;
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
    import sio_regport_pkg::*;
(
    input  logic               sel_b,
    input  logic               addr_data,
    input  logic [PW-1:0]      ptr_a,
    input  logic [PW-1:0]      ptr_b,
    input  logic [NCH*DW-1:0]  rr0_in,
    input  logic [NCH*DW-1:0]  rr1_in,
    input  logic [NCH*DW-1:0]  rr10_in,
    input  logic [NCH*DW-1:0]  rxd_in,
    input  logic [DW-1:0]      vec_in,
    input  logic [DW-1:0]      ipend_in,
    input  logic [NREG*DW-1:0] cfg_a,
    input  logic [NREG*DW-1:0] cfg_b,
    output logic [DW-1:0]      rdata
);
    logic [PW-1:0]      p;
    logic [DW-1:0]      st0, st1, st10, rxd;
    logic [NREG*DW-1:0] cfg;

    always_comb begin
        p    = sel_b ? ptr_b : ptr_a;
        st0  = sel_b ? rr0_in[2*DW-1:DW]  : rr0_in[DW-1:0];
        st1  = sel_b ? rr1_in[2*DW-1:DW]  : rr1_in[DW-1:0];
        st10 = sel_b ? rr10_in[2*DW-1:DW] : rr10_in[DW-1:0];
        rxd  = sel_b ? rxd_in[2*DW-1:DW]  : rxd_in[DW-1:0];
        cfg  = sel_b ? cfg_b : cfg_a;
        if (addr_data) begin
            rdata = rxd;
        end else begin
            case (p)
                REG_CMD:                   rdata = st0;
                REG_STAT:                  rdata = st1;
                REG_VEC:                   rdata = sel_b ? vec_in : cfg_a[int'(REG_VEC)*DW +: DW];
                REG_PEND:                  rdata = sel_b ? '0 : ipend_in;
                REG_DATA:                  rdata = rxd;
                REG_AUX:                   rdata = st10;
                REG_TCL, REG_TCH, REG_IEN: rdata = cfg[int'(p)*DW +: DW];
                default:                   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sio_regport.sv
module sio_regport
    import sio_regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_b,
    input  logic               bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NCH*DW-1:0]  rr0_in,
    input  logic [NCH*DW-1:0]  rr1_in,
    input  logic [NCH*DW-1:0]  rr10_in,
    input  logic [NCH*DW-1:0]  rxd_in,
    input  logic [DW-1:0]      vec_in,
    input  logic [DW-1:0]      ipend_in,
    output logic [NREG*DW-1:0] cfg_a,
    output logic [NREG*DW-1:0] cfg_b,
    output logic [NCMD-1:0]    cmd_a,
    output logic [NCMD-1:0]    cmd_b,
    output logic [NCH-1:0]     tx_load,
    output logic [NCH-1:0]     rx_take,
    output logic [NCH-1:0]     chan_rst
);
    logic [NCH-1:0][PW-1:0]   ptr_v;
    logic [NCH-1:0][NCMD-1:0] cmd_v;
    logic [NCH-1:0]           reg_we;
    logic [NCH-1:0]           clr_ptr;
    logic                     rd_ok;

    assign rd_ok = bus_rd && !bus_wr;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = (c == 1) ? bus_sel_b : !bus_sel_b;
        sio_chan_ptr u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (hit && bus_wr && !bus_addr),
            .ctl_rd  (hit && rd_ok && !bus_addr),
            .dat_wr  (hit && bus_wr && bus_addr),
            .dat_rd  (hit && rd_ok && bus_addr),
            .clr_ptr (clr_ptr[c]),
            .wdata   (bus_wdata),
            .ptr     (ptr_v[c]),
            .reg_we  (reg_we[c]),
            .cmd     (cmd_v[c]),
            .tx_load (tx_load[c]),
            .rx_take (rx_take[c])
        );
    end

    sio_wreg_file u_wf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .idx_a    (ptr_v[0]),
        .idx_b    (ptr_v[1]),
        .wdata    (bus_wdata),
        .cfg_a    (cfg_a),
        .cfg_b    (cfg_b),
        .clr_ptr  (clr_ptr),
        .chan_rst (chan_rst)
    );

    sio_rd_mux u_mux (
        .sel_b     (bus_sel_b),
        .addr_data (bus_addr),
        .ptr_a     (ptr_v[0]),
        .ptr_b     (ptr_v[1]),
        .rr0_in    (rr0_in),
        .rr1_in    (rr1_in),
        .rr10_in   (rr10_in),
        .rxd_in    (rxd_in),
        .vec_in    (vec_in),
        .ipend_in  (ipend_in),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .rdata     (bus_rdata)
    );

    assign cmd_a = cmd_v[0];
    assign cmd_b = cmd_v[1];
endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk
    import sio_regport_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel_b,
    input logic               bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [NREG*DW-1:0] cfg_a,
    input logic [NREG*DW-1:0] cfg_b,
    input logic [NCMD-1:0]    cmd_a,
    input logic [NCMD-1:0]    cmd_b,
    input logic [NCH-1:0]     tx_load,
    input logic [NCH-1:0]     rx_take,
    input logic [NCH-1:0]     chan_rst,
    input logic [PW-1:0]      ptr_a,
    input logic [PW-1:0]      ptr_b
);
    p_txl_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load[0] |-> $past(bus_wr && !bus_sel_b));

    p_rxt_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take[1] |-> $past(bus_rd && !bus_wr && bus_sel_b));

    p_cmd_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a != '0) |-> $past(bus_wr && !bus_addr && !bus_sel_b));

    p_cmd_ptr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_b != '0) |-> $past(ptr_b == '0));

    p_ptr_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !bus_addr && !bus_sel_b && ptr_a != '0) |=> (ptr_a == '0));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(bus_rd && !bus_addr && !bus_sel_b)) |=> $stable(ptr_a));

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(cfg_a) && $stable(cfg_b)));

    p_rst_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst != '0) |-> $past(bus_wr && !bus_addr));

    p_rst_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst == 2'b11) |-> (cfg_a == '0 && cfg_b == '0));
endmodule

bind sio_regport sio_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel_b (bus_sel_b),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cfg_a     (cfg_a),
    .cfg_b     (cfg_b),
    .cmd_a     (cmd_a),
    .cmd_b     (cmd_b),
    .tx_load   (tx_load),
    .rx_take   (rx_take),
    .chan_rst  (chan_rst),
    .ptr_a     (ptr_v[0]),
    .ptr_b     (ptr_v[1])
);

// File: tb/sio_regport_bench.sv
module sio_regport_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel_b = 1'b0, bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [15:0]  rr0_in  = 16'hB0A0;
    logic [15:0]  rr1_in  = 16'hB1A1;
    logic [15:0]  rr10_in = 16'hBAAA;
    logic [15:0]  rxd_in  = 16'h5B5A;
    logic [7:0]   vec_in   = 8'h66;
    logic [7:0]   ipend_in = 8'h2C;
    logic [127:0] cfg_a, cfg_b;
    logic [8:0]   cmd_a, cmd_b;
    logic [1:0]   tx_load, rx_take, chan_rst;
    logic [7:0]   rd;
    int           checks = 0;
    int           errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regport u_sio_regport (.*);

    typedef struct packed {
        logic       sel;
        logic [7:0] code;
        logic [8:0] exp;
    } cmd_vec_t;

    localparam cmd_vec_t CMD_TAB [12] = '{
        '{1'b0, 8'h10, 9'h001}, '{1'b1, 8'h18, 9'h002}, '{1'b0, 8'h20, 9'h004},
        '{1'b1, 8'h28, 9'h008}, '{1'b0, 8'h30, 9'h010}, '{1'b1, 8'h38, 9'h020},
        '{1'b0, 8'h40, 9'h040}, '{1'b1, 8'h80, 9'h080}, '{1'b0, 8'hC0, 9'h100},
        '{1'b1, 8'h50, 9'h041}, '{1'b0, 8'hF8, 9'h120}, '{1'b1, 8'h00, 9'h000}
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byt(input logic [127:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    task automatic bus_write(input logic sel, input logic adr, input logic [7:0] val);
        @(negedge clk);
        bus_sel_b = sel; bus_addr = adr; bus_wdata = val; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, input logic adr, output logic [7:0] val);
        @(negedge clk);
        bus_sel_b = sel; bus_addr = adr; bus_rd = 1'b1;
        #(CLK_PERIOD/4);
        val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 cfg_a zero", cfg_a, '0);
        check("R1 strobes zero", {cmd_a, cmd_b, tx_load, rx_take, chan_rst}, '0);
        bus_read(1'b0, 1'b0, rd); check("R1 ch A reads rr0", rd, 8'hA0);
        bus_read(1'b1, 1'b0, rd); check("R1 ch B reads rr0", rd, 8'hB0);

        // R6 command code table
        for (int i = 0; i < 12; i++) begin
            cmd_vec_t t;
            t = CMD_TAB[i];
            bus_write(t.sel, 1'b0, t.code);
            check("R6 cmd strobe", t.sel ? cmd_b : cmd_a, t.exp);
            check("R6 other channel quiet", t.sel ? cmd_a : cmd_b, '0);
            bus_read(t.sel, 1'b0, rd);
            check("R6 pointer stays zero", rd, t.sel ? 8'hB0 : 8'hA0);
        end
        check("R6 codes not stored", cfg_a, '0);

        // R2 R4 R3 pointer load, store, fall back
        bus_write(1'b0, 1'b0, 8'h05); bus_write(1'b0, 1'b0, 8'h3C);
        check("R4 byte 5 stored", byt(cfg_a, 5), 8'h3C);
        bus_read(1'b0, 1'b0, rd); check("R3 pointer back after write", rd, 8'hA0);
        bus_write(1'b0, 1'b0, 8'h01); bus_read(1'b0, 1'b0, rd);
        check("R7 reg 1 reads rr1", rd, 8'hA1);
        bus_read(1'b0, 1'b0, rd); check("R3 pointer back after read", rd, 8'hA0);
        bus_write(1'b0, 1'b0, 8'h0C); bus_write(1'b0, 1'b0, 8'h77);
        check("R2 point-high reaches 12", byt(cfg_a, 12), 8'h77);
        bus_write(1'b0, 1'b0, 8'h0C); bus_read(1'b0, 1'b0, rd);
        check("R7 reg 12 readback", rd, 8'h77);
        bus_write(1'b1, 1'b0, 8'h0A); bus_read(1'b1, 1'b0, rd);
        check("R7 reg 10 ch B", rd, 8'hBA);
        bus_write(1'b0, 1'b0, 8'h04); bus_read(1'b0, 1'b0, rd);
        check("R7 reg 4 reads zero", rd, 8'h00);
        bus_write(1'b0, 1'b0, 8'h0E); bus_read(1'b0, 1'b0, rd);
        check("R7 reg 14 reads zero", rd, 8'h00);

        // R5 data path
        bus_write(1'b0, 1'b0, 8'h08); bus_write(1'b0, 1'b0, 8'h99);
        check("R5 ctl reg 8 tx_load", tx_load, 2'b01);
        check("R5 reg 8 not stored", byt(cfg_a, 8), 8'h00);
        bus_write(1'b1, 1'b1, 8'h42);
        check("R5 data write ch B", tx_load, 2'b10);
        bus_read(1'b0, 1'b1, rd);
        check("R5 data read ch A", rd, 8'h5A);
        check("R5 rx_take ch A", rx_take, 2'b01);
        bus_write(1'b1, 1'b0, 8'h08); bus_read(1'b1, 1'b0, rd);
        check("R5 ctl reg 8 read ch B", rd, 8'h5B);
        check("R5 rx_take ch B", rx_take, 2'b10);

        // R8 shared vector, R7 pending register
        bus_write(1'b1, 1'b0, 8'h02); bus_write(1'b1, 1'b0, 8'h4E);
        check("R8 shared byte on A", byt(cfg_a, 2), 8'h4E);
        check("R8 shared byte on B", byt(cfg_b, 2), 8'h4E);
        bus_write(1'b0, 1'b0, 8'h02); bus_read(1'b0, 1'b0, rd);
        check("R8 ch A reads stored", rd, 8'h4E);
        bus_write(1'b1, 1'b0, 8'h02); bus_read(1'b1, 1'b0, rd);
        check("R8 ch B reads vec_in", rd, 8'h66);
        bus_write(1'b0, 1'b0, 8'h03); bus_read(1'b0, 1'b0, rd);
        check("R7 reg 3 ch A", rd, 8'h2C);
        bus_write(1'b1, 1'b0, 8'h03); bus_read(1'b1, 1'b0, rd);
        check("R7 reg 3 ch B zero", rd, 8'h00);

        // R10 independence
        bus_write(1'b0, 1'b0, 8'h05);
        bus_read(1'b1, 1'b0, rd); check("R10 ch B pointer untouched", rd, 8'hB0);
        bus_write(1'b0, 1'b0, 8'h38);
        check("R10 ch A pointer kept", byt(cfg_a, 5), 8'h38);
        check("R6 no strobe at nonzero pointer", cmd_a, '0);

        // R9 master register
        bus_write(1'b1, 1'b0, 8'h05); bus_write(1'b1, 1'b0, 8'h11);
        check("R4 ch B byte 5", byt(cfg_b, 5), 8'h11);
        bus_write(1'b0, 1'b0, 8'h09); bus_write(1'b0, 1'b0, 8'h4B);
        check("R9 chan B reset strobe", chan_rst, 2'b10);
        check("R9 ch B byte cleared", byt(cfg_b, 5), 8'h00);
        check("R9 ch A byte kept", byt(cfg_a, 5), 8'h38);
        check("R9 stored without reset bits A", byt(cfg_a, 9), 8'h0B);
        check("R9 shared view on B", byt(cfg_b, 9), 8'h0B);
        check("R9 shared vector survives", byt(cfg_a, 2), 8'h4E);
        bus_write(1'b1, 1'b0, 8'h03);
        bus_write(1'b0, 1'b0, 8'h09); bus_write(1'b0, 1'b0, 8'hC0);
        check("R9 full reset strobe", chan_rst, 2'b11);
        check("R9 full clears A", cfg_a, '0);
        check("R9 full clears B", cfg_b, '0);
        bus_read(1'b1, 1'b0, rd); check("R9 ch B pointer cleared", rd, 8'hB0);

        finish_run();
    end
endmodule